// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns level changes on sixteen external pins into latched interrupt requests. Each of the sixteen interrupt lines picks its source pin from one of several GPIO port input vectors. The pick is made by a 4-bit port code per line. Line n always takes bit n of the chosen port. The chosen pin is brought into the clock domain through two flops and then compared with its value one cycle earlier. A transition of a kind that software has enabled for that line (low-to-high, high-to-low, or either) sets the line's pending flag.

Pending flags are kept whether or not the line is enabled. The enable bits only decide which pending flags reach the request outputs. The request outputs are grouped: lines 0 to 4 each own one output, lines 5 to 9 share one, and lines 10 to 15 share another. That gives seven outputs. Software clears a flag by writing a 1 to its bit in the pending register.

Software reaches the controller through a plain register port. A write is a single cycle with `regWrEn` high. A read returns data combinationally for the address presented. Address bits [1:0] are ignored.

Top module: `extint_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0 and all seven request outputs are low.
- R2: With its rising-select bit set, a line's pending flag, and its request if enabled, become visible after the third rising clock edge following a low-to-high change on the selected pin. After the second edge they are not yet visible.
- R3: With its falling-select bit set, a high-to-low change sets the pending flag. With both select bits set, changes in either direction set it.
- R4: A transition whose direction is not selected for a line leaves that line's pending flag at 0.
- R5: Writing the pending register (word offset 0x0C) clears every flag whose data bit is 1. Flags whose data bit is 0 stay unchanged.
- R6: The enable register (offset 0x00, bit n = line n) gates only the request outputs. A disabled line still latches its pending flag, and its request rises as soon as the line is enabled.
- R7: If a selected edge and a clearing write hit the same line in the same cycle, the flag ends up set.
- R8: Output k (k = 0 to 4) carries enabled-pending line k. Output 5 is the OR of enabled-pending lines 5 to 9. Output 6 is the OR of enabled-pending lines 10 to 15.
- R9: Line n takes its port code from the port-select register at offset 0x10 + 4*(n/4), bits (n mod 4)*4 + 3 down to (n mod 4)*4. Code p below the number of ports selects bit n of port p. Any other code gives a constant 0. Bits 31:16 of these registers read 0.
- R10: A new selected edge after a flag has been cleared sets the flag again and reasserts the request.
- R11: The rising-select register is at 0x04 and the falling-select register at 0x08, with bit n = line n. Offsets 0x20 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gpioIn | input | NUM_PORTS*16 | Port input vectors; bit p*16+n is pin n of port p |
| regWrEn | input | 1 | Write strobe for one cycle |
| regAddr | input | ADDR_W | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| irqOut | output | 7 | Grouped interrupt requests |

## Verification
Single lines are toggled with rising-only, falling-only and both-edge selection. This separates the direction filters from one another and from lines with no selection. A line that is disabled while an edge arrives shows whether the mask gates the flag or only the request. Edges on grouped lines show whether each shared output merges its own members and no others. A clear written in the same cycle as a fresh edge distinguishes set-priority from clear-priority. Toggling an unselected port's pin, and the pins behind an out-of-range code, shows that the port multiplexer picks only the coded source.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int LINES          = 16;
  localparam int SEL_W          = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int SEL_REGS       = LINES / FIELDS_PER_REG;
  localparam int SEL_BITS       = SEL_W * FIELDS_PER_REG;
  localparam int IDX_W          = $clog2(SEL_REGS);
  localparam int DATA_W         = 32;
  localparam int SOLO_LINES     = 5;
  localparam int GRP_A_LO       = 5;
  localparam int GRP_A_HI       = 9;
  localparam int GRP_B_LO       = 10;
  localparam int IRQ_OUTS       = SOLO_LINES + 2;

  typedef struct packed {
    logic                wrMask;
    logic                wrRise;
    logic                wrFall;
    logic                wrPend;
    logic [SEL_REGS-1:0] wrSel;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASK, RD_RISE, RD_FALL, RD_PEND, RD_SEL
  } rd_src_t;

  typedef struct packed {
    rd_src_t          src;
    logic [IDX_W-1:0] idx;
  } rd_sel_t;
endpackage

// File: rtl/extint_regif.sv
module extint_regif
  import extint_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output rd_sel_t           rdSel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  assign wordIdx = regAddr[ADDR_W-1:2];

  always_comb begin
    strb  = '0;
    rdSel = '{src: RD_NONE, idx: '0};
    if (wordIdx < WORD_W'(4)) begin
      case (wordIdx[1:0])
        2'd0: begin rdSel.src = RD_MASK; strb.wrMask = regWrEn; end
        2'd1: begin rdSel.src = RD_RISE; strb.wrRise = regWrEn; end
        2'd2: begin rdSel.src = RD_FALL; strb.wrFall = regWrEn; end
        default: begin rdSel.src = RD_PEND; strb.wrPend = regWrEn; end
      endcase
    end else if (wordIdx < WORD_W'(4 + SEL_REGS)) begin
      rdSel.src = RD_SEL;
      rdSel.idx = IDX_W'(wordIdx - WORD_W'(4));
      strb.wrSel[rdSel.idx] = regWrEn;
    end
  end

  // R11: at most one register is written per cycle
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrMask, strb.wrRise, strb.wrFall, strb.wrPend, strb.wrSel}));

  // R11: addresses past the map neither read nor write
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (wordIdx >= WORD_W'(4 + SEL_REGS)) |-> (rdSel.src == RD_NONE && strb == '0));
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*LINES-1:0] gpioIn,
  input  strobe_t                    strb,
  input  rd_sel_t                    rdSel,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [IRQ_OUTS-1:0]        irqOut
);
  logic [LINES-1:0] maskReg, riseReg, fallReg, pendReg;
  logic [LINES-1:0] syncA, syncB, prevB;
  logic [LINES-1:0] pinSel, riseHit, fallHit, edgeHit, clrMask, active;
  logic [LINES*SEL_W-1:0] selReg;

  // port multiplexer per line
  always_comb begin
    logic [SEL_W-1:0] code;
    code   = '0;
    pinSel = '0;
    for (int n = 0; n < LINES; n++) begin
      code = selReg[n*SEL_W +: SEL_W];
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (code == SEL_W'(p)) pinSel[n] = gpioIn[p*LINES + n];
      end
    end
  end

  assign riseHit = syncB & ~prevB & riseReg;
  assign fallHit = ~syncB & prevB & fallReg;
  assign edgeHit = riseHit | fallHit;
  assign clrMask = strb.wrPend ? wrData[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= '0;
      syncB   <= '0;
      prevB   <= '0;
      pendReg <= '0;
      maskReg <= '0;
      riseReg <= '0;
      fallReg <= '0;
      selReg  <= '0;
    end else begin
      syncA   <= pinSel;
      syncB   <= syncA;
      prevB   <= syncB;
      pendReg <= (pendReg & ~clrMask) | edgeHit;
      if (strb.wrMask) maskReg <= wrData[LINES-1:0];
      if (strb.wrRise) riseReg <= wrData[LINES-1:0];
      if (strb.wrFall) fallReg <= wrData[LINES-1:0];
      for (int r = 0; r < SEL_REGS; r++) begin
        if (strb.wrSel[r]) selReg[r*SEL_BITS +: SEL_BITS] <= wrData[SEL_BITS-1:0];
      end
    end
  end

  // request grouping
  assign active = pendReg & maskReg;
  genvar k;
  generate
    for (k = 0; k < SOLO_LINES; k++) begin : g_solo
      assign irqOut[k] = active[k];
      // R6: a disabled dedicated line never requests
      assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !maskReg[k] |-> !irqOut[k]);
    end
  endgenerate
  assign irqOut[SOLO_LINES]     = |active[GRP_A_HI:GRP_A_LO];
  assign irqOut[SOLO_LINES + 1] = |active[LINES-1:GRP_B_LO];

  always_comb begin
    case (rdSel.src)
      RD_MASK: rdData = DATA_W'(maskReg);
      RD_RISE: rdData = DATA_W'(riseReg);
      RD_FALL: rdData = DATA_W'(fallReg);
      RD_PEND: rdData = DATA_W'(pendReg);
      RD_SEL:  rdData = DATA_W'(selReg[rdSel.idx*SEL_BITS +: SEL_BITS]);
      default: rdData = '0;
    endcase
  end

  // R5: written ones clear the flags unless a new edge lands on them
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    strb.wrPend |=> ((pendReg & $past(wrData[LINES-1:0] & ~edgeHit)) == '0));

  // R7: a detected edge always leaves its flag set
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|edgeHit) |=> ((pendReg & $past(edgeHit)) == $past(edgeHit)));

  // R8: shared output stays low while all its members are disabled
  assert_group_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (maskReg[GRP_A_HI:GRP_A_LO] == '0) |-> !irqOut[SOLO_LINES]);

  genvar n;
  generate
    for (n = 0; n < LINES; n++) begin : g_line
      // R4: a flag only rises after the synchronized pin changed
      assert_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pendReg[n]) |-> $past(syncB[n] != prevB[n]));
    end
  endgenerate
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*LINES-1:0] gpioIn,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  output logic [IRQ_OUTS-1:0]        irqOut
);
  strobe_t strb;
  rd_sel_t rdSel;

  extint_regif #(.ADDR_W(ADDR_W)) uRegif (
    .clk     (clk),
    .rst     (rst),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  extint_datapath #(.NUM_PORTS(NUM_PORTS)) uPath (
    .clk    (clk),
    .rst    (rst),
    .gpioIn (gpioIn),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (regWrData),
    .rdData (regRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/extint_ctrl_test.sv
`timescale 1ns/100ps
module extint_ctrl_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] gpio = '0;
  logic        regWrEn = 0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [6:0]  irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  extint_ctrl uut (
    .clk(clk), .rst(rst), .gpioIn(gpio), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [15:0] mMask, mRise, mFall, mPend, s1, s2, pv, ev, clr, pinNow;
  logic [63:0] mSel;
  int code;

  always @(posedge clk) begin
    if (rst) begin
      mMask = 0; mRise = 0; mFall = 0; mPend = 0; mSel = 0;
      s1 = 0; s2 = 0; pv = 0;
    end else begin
      for (int n = 0; n < 16; n++) begin
        code = int'((mSel >> (n*4)) & 64'hF);
        pinNow[n] = (code < 4) ? gpio[code*16 + n] : 1'b0;
        ev[n] = (mRise[n] && s2[n] && !pv[n]) || (mFall[n] && !s2[n] && pv[n]);
      end
      clr = (regWrEn && regAddr[5:2] == 4'd3) ? regWrData[15:0] : 16'h0;
      mPend = (mPend & ~clr) | ev;
      pv = s2; s2 = s1; s1 = pinNow;
      if (regWrEn) begin
        case (regAddr[5:2])
          4'd0: mMask = regWrData[15:0];
          4'd1: mRise = regWrData[15:0];
          4'd2: mFall = regWrData[15:0];
          4'd4, 4'd5, 4'd6, 4'd7: mSel[(regAddr[5:2] - 4'd4)*16 +: 16] = regWrData[15:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    case (a[5:2])
      4'd0: return {16'h0, mMask};
      4'd1: return {16'h0, mRise};
      4'd2: return {16'h0, mFall};
      4'd3: return {16'h0, mPend};
      4'd4, 4'd5, 4'd6, 4'd7: return {16'h0, mSel[(a[5:2] - 4'd4)*16 +: 16]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [6:0] modelIrq();
    logic [15:0] act;
    act = mPend & mMask;
    return {|act[15:10], |act[9:5], act[4:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!rst && !done) begin
      check("R8 cycle irq", 32'(irqOut), 32'(modelIrq()));
      check("R11 cycle read", regRdData, modelRead(regAddr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pin(input int port, input int line, input logic v);
    @(negedge clk);
    gpio[port*16 + line] = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    for (int a = 0; a < 8; a++) begin
      rd(6'(a*4), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 reset irq", 32'(irqOut), 32'h0);

    wr(6'h00, 32'hFFFF);
    wr(6'h04, 32'h0005);
    wr(6'h08, 32'h0006);
    rd(6'h04, d); check("R11 rise select readback", d, 32'h5);
    rd(6'h08, d); check("R11 fall select readback", d, 32'h6);

    // R2 latency on line 0
    @(negedge clk); gpio[0] = 1;
    @(negedge clk);
    @(negedge clk); check("R2 not yet after two edges", 32'(irqOut[0]), 32'h0);
    @(negedge clk); check("R2 set after three edges", 32'(irqOut[0]), 32'h1);

    // R5
    wr(6'h0C, 32'h0000);
    rd(6'h0C, d); check("R5 zero write keeps flag", d, 32'h1);
    wr(6'h0C, 32'h0001);
    rd(6'h0C, d); check("R5 one write clears flag", d, 32'h0);

    // R4 and R3 on line 1 (falling only)
    pin(0, 1, 1);
    rd(6'h0C, d); check("R4 unselected rise ignored", d, 32'h0);
    pin(0, 1, 0);
    check("R3 falling edge request", 32'(irqOut[1]), 32'h1);
    wr(6'h0C, 32'h2);

    // R3 both edges on line 2
    pin(0, 2, 1);
    rd(6'h0C, d); check("R3 both: rise", d, 32'h4);
    wr(6'h0C, 32'h4);
    pin(0, 2, 0);
    rd(6'h0C, d); check("R3 both: fall", d, 32'h4);
    wr(6'h0C, 32'h4);

    // R10 re-trigger on line 0
    pin(0, 0, 0);
    rd(6'h0C, d); check("R4 unselected fall ignored", d, 32'h0);
    pin(0, 0, 1);
    check("R10 request after re-trigger", 32'(irqOut[0]), 32'h1);
    wr(6'h0C, 32'h1);

    // R6 masked line 3
    wr(6'h00, 32'hFFF7);
    wr(6'h04, 32'h000D);
    pin(0, 3, 1);
    check("R6 masked line no request", 32'(irqOut[3]), 32'h0);
    rd(6'h0C, d); check("R6 masked line still pending", d, 32'h8);
    wr(6'h00, 32'hFFFF);
    check("R6 request after enable", 32'(irqOut[3]), 32'h1);
    wr(6'h0C, 32'h8);

    // R8 grouping
    wr(6'h04, 32'h1081);
    pin(0, 7, 1);
    check("R8 group A", 32'(irqOut), 32'h20);
    pin(0, 12, 1);
    check("R8 both groups", 32'(irqOut), 32'h60);
    wr(6'h0C, 32'h80);
    check("R8 group B alone", 32'(irqOut), 32'h40);
    wr(6'h0C, 32'h1000);

    // R9 port selection
    wr(6'h1C, 32'hFFFF0920);
    rd(6'h1C, d); check("R9 select readback upper bits zero", d, 32'h920);
    wr(6'h04, 32'h6000);
    pin(0, 13, 1);
    rd(6'h0C, d); check("R9 unselected port ignored", d, 32'h0);
    pin(2, 13, 1);
    rd(6'h0C, d); check("R9 selected port edge", d, 32'h2000);
    wr(6'h0C, 32'h2000);
    for (int p = 0; p < 4; p++) gpio[p*16 + 14] = 1;
    repeat (4) @(negedge clk);
    rd(6'h0C, d); check("R9 out-of-range code reads 0", d, 32'h0);

    // R7 same-cycle edge and clear on line 4
    wr(6'h04, 32'h0010);
    pin(0, 4, 1);
    pin(0, 4, 0);
    @(negedge clk); gpio[4] = 1;
    @(negedge clk);
    @(negedge clk); regWrEn = 1; regAddr = 6'h0C; regWrData = 32'h10;
    @(negedge clk); regWrEn = 0;
    rd(6'h0C, d); check("R7 edge wins over clear", d, 32'h10);
    wr(6'h0C, 32'h10);
    rd(6'h0C, d); check("R7 later clear takes effect", d, 32'h0);

    // R11 unmapped
    wr(6'h24, 32'hFFFF);
    rd(6'h24, d); check("R11 unmapped reads 0", d, 32'h0);
    rd(6'h00, d); check("R11 unmapped write harmless", d, 32'hFFFF);
    rd(6'h04, d); check("R11 rise register unchanged", d, 32'h10);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule